// File: doc/BRIEF.md
# Double-Buffered Instruction Dispatch Controller

This block sits in front of a compute engine that runs long, multi-cycle macro-instructions. It holds two 192-bit instruction slots. A host fills them in turn, so the next instruction can be staged while the current one runs. When a slot holds a valid instruction and the engine is free, the controller decodes the opcode and the operand fields and sends the engine a one-cycle start pulse. The engine reports the end of the instruction with a done pulse. The controller then clears that slot and, on the following cycle, launches the other slot if it holds work. If the other slot is empty, the controller goes idle.

A status word shows busy, which slot is active, the two slot-valid flags and three sticky flags: completion, rejected write and illegal opcode. The host clears the sticky flags with a single clear strobe. The wake output follows the completion flag. A host whose clock has been gated can therefore sleep until an instruction finishes and stay awake until it acknowledges. The execution engines themselves are outside this block.

Top module: `dbl_instr_ctrl`

## Requirements
- R1: After reset the status word is zero, exec_start is low and wake is low. Status bits are: [0] busy, [1] active slot index, [2] slot 0 valid, [3] slot 1 valid, [4] completion, [5] rejected write, [6] illegal opcode, [7] zero.
- R2: A host write to a slot sets that slot's valid bit at the edge where the write is sampled. If the controller is idle, the next edge raises exec_start for exactly one cycle, together with busy and the active index.
- R3: The fields of the active slot appear on the exec outputs with this layout: opcode at [3:0], source address at [19:4], destination address at [35:20], size at [51:36], weight precision at [55:52], neuron precision at [59:56], and flags at [191:60]. Opcodes 1, 2, 3 and 4 (fully-connected, FFT, block move, table activation) map to exec_kind 0, 1, 2 and 3.
- R4: A host write to the slot that is currently executing is dropped. It sets the rejected-write flag and leaves the running instruction's fields unchanged. A write to the other slot is still accepted.
- R5: A done pulse while busy clears the active slot's valid bit and busy, and sets the completion flag. wake is high whenever the completion flag is set.
- R6: If the other slot is valid when done arrives, that slot is started by an exec_start pulse one edge after the done edge.
- R7: If the other slot is empty when done arrives, the controller stays idle, with busy low and no start pulse.
- R8: An opcode outside 1 to 4 is never started. The slot's valid bit is cleared, the illegal flag is set, the active index points at that slot and busy stays low.
- R9: A host_clr strobe clears the completion, rejected-write and illegal flags, and wake falls with the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | Slot selected by the write |
| host_word | input | 192 | Instruction word to store |
| host_clr | input | 1 | Clears the sticky status flags |
| exec_done | input | 1 | Engine finished the active instruction |
| exec_start | output | 1 | One-cycle launch pulse |
| exec_kind | output | 2 | Decoded operation kind |
| exec_src | output | 16 | Source start address |
| exec_dst | output | 16 | Destination address |
| exec_len | output | 16 | Transfer or vector size |
| exec_wprec | output | 4 | Weight precision code |
| exec_nprec | output | 4 | Neuron precision code |
| exec_flags | output | 132 | Operation-specific flags |
| wake | output | 1 | Host wake request |
| status | output | 8 | Status word |

## Verification
A slot-valid bit left set after done would show at the ports one edge later, as a second exec_start for the same instruction. A valid bit cleared too early would instead show as a missing start after the done edge. A wrong active index would put the other slot's source address on exec_src in the same cycle as the start pulse, and would flip status bit 1. A write that overwrote the running slot would change exec_src while busy is still high. Each of these faults is visible within one or two cycles of the event that caused it.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int WORD_W = 192;
  localparam int OPC_W  = 4;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 16;
  localparam int PREC_W = 4;
  localparam int SRC_LO = OPC_W;
  localparam int DST_LO = SRC_LO + ADDR_W;
  localparam int LEN_LO = DST_LO + ADDR_W;
  localparam int WP_LO  = LEN_LO + LEN_W;
  localparam int NP_LO  = WP_LO + PREC_W;
  localparam int FLG_LO = NP_LO + PREC_W;
  localparam int FLG_W  = WORD_W - FLG_LO;
  localparam int SLOTS  = 2;

  typedef enum logic [1:0] {K_FC, K_FFT, K_MOVE, K_LUT} kind_e;

  typedef struct packed {
    logic               legal;
    kind_e              kind;
    logic [ADDR_W-1:0]  src;
    logic [ADDR_W-1:0]  dst;
    logic [LEN_W-1:0]   len;
    logic [PREC_W-1:0]  wprec;
    logic [PREC_W-1:0]  nprec;
    logic [FLG_W-1:0]   flags;
  } fields_t;

  // opcodes 1..4 are defined; kind is opcode minus one
  function automatic fields_t split_word(logic [WORD_W-1:0] w);
    fields_t f;
    logic [OPC_W-1:0] op;
    op      = w[OPC_W-1:0];
    f.legal = (op >= 4'd1) && (op <= 4'd4);
    f.kind  = kind_e'(op[1:0] - 2'd1);
    f.src   = w[SRC_LO +: ADDR_W];
    f.dst   = w[DST_LO +: ADDR_W];
    f.len   = w[LEN_LO +: LEN_W];
    f.wprec = w[WP_LO +: PREC_W];
    f.nprec = w[NP_LO +: PREC_W];
    f.flags = w[FLG_LO +: FLG_W];
    return f;
  endfunction
endpackage

// File: rtl/dic_slot.sv
module dic_slot
  import dic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] data,
  input  logic              drop,
  output logic [WORD_W-1:0] word,
  output logic              valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      valid <= 1'b0;
    end else begin
      if (drop) valid <= 1'b0;
      if (load) begin
        word  <= data;
        valid <= 1'b1;
      end
    end
  end

  // R5 / R8: a dropped slot is empty afterwards unless reloaded
  p_drop_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !load |=> !valid);
  // R2: a load always leaves the slot valid
  p_load_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid);
endmodule

// File: rtl/dic_decode.sv
module dic_decode
  import dic_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output fields_t           fields
);
  always_comb fields = split_word(word);
endmodule

// File: rtl/dic_seq.sv
module dic_seq
  import dic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] valid,
  input  logic [SLOTS-1:0] legal,
  input  logic             done,
  input  logic             reject,
  input  logic             clr_flags,
  output logic             busy,
  output logic             act,
  output logic             start,
  output logic [SLOTS-1:0] drop,
  output logic             cmp_flag,
  output logic             err_flag,
  output logic             ill_flag
);
  logic cand, dispatch, bad_pick, finish;

  // prefer the slot not run last; fall back to the same slot
  always_comb begin
    cand     = valid[~act] ? ~act : act;
    dispatch = !busy && (|valid);
    bad_pick = dispatch && !legal[cand];
    finish   = busy && done;
    for (int i = 0; i < SLOTS; i++)
      drop[i] = (finish && act == 1'(i)) || (bad_pick && cand == 1'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      act      <= 1'b0;
      start    <= 1'b0;
      cmp_flag <= 1'b0;
      err_flag <= 1'b0;
      ill_flag <= 1'b0;
    end else begin
      start <= 1'b0;
      if (clr_flags) begin
        cmp_flag <= 1'b0;
        err_flag <= 1'b0;
        ill_flag <= 1'b0;
      end
      if (dispatch) begin
        act <= cand;
        if (legal[cand]) begin
          busy  <= 1'b1;
          start <= 1'b1;
        end else begin
          ill_flag <= 1'b1;
        end
      end
      if (finish) begin
        busy     <= 1'b0;
        cmp_flag <= 1'b1;
      end
      if (reject) err_flag <= 1'b1;
    end
  end

  p_start_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> busy);
  p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
  p_done_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy && cmp_flag);
  p_illegal_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_pick |=> !start && !busy && ill_flag);
  p_reject_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> err_flag);
  p_clear_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flags && !finish && !reject && !bad_pick |=> !cmp_flag && !err_flag && !ill_flag);
endmodule

// File: rtl/dbl_instr_ctrl.sv
module dbl_instr_ctrl
  import dic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [WORD_W-1:0] host_word,
  input  logic              host_clr,
  input  logic              exec_done,
  output logic              exec_start,
  output logic [1:0]        exec_kind,
  output logic [ADDR_W-1:0] exec_src,
  output logic [ADDR_W-1:0] exec_dst,
  output logic [LEN_W-1:0]  exec_len,
  output logic [PREC_W-1:0] exec_wprec,
  output logic [PREC_W-1:0] exec_nprec,
  output logic [FLG_W-1:0]  exec_flags,
  output logic              wake,
  output logic [7:0]        status
);
  logic [SLOTS-1:0][WORD_W-1:0] words;
  fields_t [SLOTS-1:0]          dec;
  logic [SLOTS-1:0]             valid, legal, drop, load;
  logic                         busy, act, reject;
  logic                         cmp_flag, err_flag, ill_flag;
  fields_t                      cur;

  assign reject = host_wr && busy && (host_sel == act);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign load[g] = host_wr && (host_sel == 1'(g)) && !reject;
    dic_slot u_slot (
      .clk(clk), .rst_n(rst_n), .load(load[g]), .data(host_word),
      .drop(drop[g]), .word(words[g]), .valid(valid[g])
    );
    dic_decode u_dec (.word(words[g]), .fields(dec[g]));
    assign legal[g] = dec[g].legal;
  end

  dic_seq u_seq (
    .clk(clk), .rst_n(rst_n), .valid(valid), .legal(legal),
    .done(exec_done), .reject(reject), .clr_flags(host_clr),
    .busy(busy), .act(act), .start(exec_start), .drop(drop),
    .cmp_flag(cmp_flag), .err_flag(err_flag), .ill_flag(ill_flag)
  );

  assign cur        = dec[act];
  assign exec_kind  = cur.kind;
  assign exec_src   = cur.src;
  assign exec_dst   = cur.dst;
  assign exec_len   = cur.len;
  assign exec_wprec = cur.wprec;
  assign exec_nprec = cur.nprec;
  assign exec_flags = cur.flags;
  assign wake       = cmp_flag;
  assign status     = {1'b0, ill_flag, err_flag, cmp_flag, valid[1], valid[0], act, busy};

  // R4: a rejected write leaves the running slot's word untouched
  p_reject_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> words[$past(host_sel)] == $past(words[host_sel]));
  // R5: completion raises wake
  p_wake_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && exec_done |=> wake);
  // R2: a running instruction's slot stays valid until done
  p_run_slot_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> valid[act]);
endmodule

// File: tb/sim_dbl_instr_ctrl.sv
module sim_dbl_instr_ctrl;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n, host_wr, host_sel, host_clr, exec_done;
  logic [191:0] host_word;
  logic         exec_start, wake;
  logic [1:0]   exec_kind;
  logic [15:0]  exec_src, exec_dst, exec_len;
  logic [3:0]   exec_wprec, exec_nprec;
  logic [131:0] exec_flags;
  logic [7:0]   status;
  int           errors = 0;
  int           checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbl_instr_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_word(host_word), .host_clr(host_clr), .exec_done(exec_done),
    .exec_start(exec_start), .exec_kind(exec_kind), .exec_src(exec_src),
    .exec_dst(exec_dst), .exec_len(exec_len), .exec_wprec(exec_wprec),
    .exec_nprec(exec_nprec), .exec_flags(exec_flags), .wake(wake), .status(status)
  );

  function automatic logic [191:0] mk(logic [3:0] op, logic [15:0] src, logic [15:0] dst,
                                      logic [15:0] len, logic [3:0] wp, logic [3:0] np,
                                      logic [131:0] fl);
    return {fl, np, wp, len, dst, src, op};
  endfunction

  // bit order: ill err cmp v1 v0 act busy
  function automatic logic [7:0] st(bit ill, bit err, bit cmp, bit v1, bit v0, bit a, bit b);
    return {1'b0, ill, err, cmp, v1, v0, a, b};
  endfunction

  task automatic chk(string tag, logic [191:0] got, logic [191:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; host_wr = 0; host_sel = 0; host_clr = 0; exec_done = 0; host_word = '0;
    #(CLK_PERIOD*2);
    @(negedge clk); rst_n = 1'b1;
    tick();
  endtask

  task automatic wr(bit sel, logic [191:0] w);
    host_wr = 1; host_sel = sel; host_word = w;
    tick();
    host_wr = 0;
  endtask

  task automatic finish_one;
    exec_done = 1; tick(); exec_done = 0;
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1 status", 192'(status), 0);
    chk("R1 start", 192'(exec_start), 0);
    chk("R1 wake", 192'(wake), 0);
  endtask

  task automatic t_single;
    do_reset();
    wr(0, mk(4'd1, 16'h1234, 16'hBEEF, 16'h0040, 4'd3, 4'd5, 132'hA5));
    chk("R2 valid after write", 192'(status), 192'(st(0,0,0,0,1,0,0)));
    chk("R2 no start yet", 192'(exec_start), 0);
    tick();
    chk("R2 start", 192'(exec_start), 1);
    chk("R2 status running", 192'(status), 192'(st(0,0,0,0,1,0,1)));
    chk("R3 kind", 192'(exec_kind), 0);
    chk("R3 src", 192'(exec_src), 192'h1234);
    chk("R3 dst", 192'(exec_dst), 192'hBEEF);
    chk("R3 len", 192'(exec_len), 192'h40);
    chk("R3 wprec", 192'(exec_wprec), 3);
    chk("R3 nprec", 192'(exec_nprec), 5);
    chk("R3 flags", 192'(exec_flags), 192'hA5);
    tick();
    chk("R2 start one cycle", 192'(exec_start), 0);
    finish_one();
    chk("R5 status after done", 192'(status), 192'(st(0,0,1,0,0,0,0)));
    chk("R5 wake", 192'(wake), 1);
    tick();
    chk("R7 stays idle", 192'(exec_start), 0);
    chk("R5 wake held", 192'(wake), 1);
    host_clr = 1; tick(); host_clr = 0;
    chk("R9 flags cleared", 192'(status), 0);
    chk("R9 wake low", 192'(wake), 0);
  endtask

  task automatic t_pingpong;
    do_reset();
    wr(0, mk(4'd2, 16'h1111, 16'h0, 16'h8, 4'd1, 4'd1, 132'h0));
    wr(1, mk(4'd3, 16'h2222, 16'h3333, 16'h10, 4'd2, 4'd2, 132'h7));
    chk("R2 slot0 started", 192'(exec_start), 1);
    chk("R6 both valid", 192'(status), 192'(st(0,0,0,1,1,0,1)));
    chk("R3 FFT kind", 192'(exec_kind), 1);
    finish_one();
    chk("R6 gap cycle", 192'(status), 192'(st(0,0,1,1,0,0,0)));
    chk("R6 no start at done", 192'(exec_start), 0);
    tick();
    chk("R6 other started", 192'(exec_start), 1);
    chk("R6 status slot1", 192'(status), 192'(st(0,0,1,1,0,1,1)));
    chk("R6 slot1 src", 192'(exec_src), 192'h2222);
    chk("R3 move kind", 192'(exec_kind), 2);
    finish_one();
    tick();
    chk("R7 idle after last", 192'(status), 192'(st(0,0,1,0,0,1,0)));
    chk("R7 no start", 192'(exec_start), 0);
  endtask

  task automatic t_reject;
    do_reset();
    wr(0, mk(4'd4, 16'h1111, 16'h0, 16'h1, 4'd0, 4'd0, 132'h0));
    tick();
    wr(0, mk(4'd1, 16'h9999, 16'h0, 16'h1, 4'd0, 4'd0, 132'h0));
    chk("R4 error flag", 192'(status), 192'(st(0,1,0,0,1,0,1)));
    chk("R4 running src kept", 192'(exec_src), 192'h1111);
    chk("R4 running kind kept", 192'(exec_kind), 3);
    wr(1, mk(4'd1, 16'h5555, 16'h0, 16'h1, 4'd0, 4'd0, 132'h0));
    chk("R4 other slot accepted", 192'(status), 192'(st(0,1,0,1,1,0,1)));
    finish_one();
    tick();
    chk("R6 slot1 after reject", 192'(exec_src), 192'h5555);
    finish_one();
    chk("R4 slot0 not refilled", 192'(status), 192'(st(0,1,1,0,0,1,0)));
  endtask

  task automatic t_illegal;
    do_reset();
    wr(1, mk(4'd0, 16'h7, 16'h0, 16'h1, 4'd0, 4'd0, 132'h0));
    tick();
    chk("R8 op0 no start", 192'(exec_start), 0);
    chk("R8 op0 status", 192'(status), 192'(st(1,0,0,0,0,1,0)));
    wr(0, mk(4'd9, 16'h7, 16'h0, 16'h1, 4'd0, 4'd0, 132'h0));
    tick();
    chk("R8 op9 no start", 192'(exec_start), 0);
    chk("R8 op9 status", 192'(status), 192'(st(1,0,0,0,0,0,0)));
    tick();
    chk("R8 still idle", 192'(exec_start), 0);
  endtask

  task automatic t_kinds;
    do_reset();
    for (int op = 1; op <= 4; op++) begin
      wr(0, mk(4'(op), 16'(op*3), 16'h0, 16'h1, 4'd0, 4'd0, 132'h0));
      tick();
      chk("R3 kind sweep", 192'(exec_kind), 192'(op-1));
      chk("R3 src sweep", 192'(exec_src), 192'(op*3));
      finish_one();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_pingpong();
    t_reject();
    t_illegal();
    t_kinds();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule